// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the pin levels of a GPIO bank into per-pin interrupt requests and one combined interrupt line. Each pin first passes through a two-flop synchronizer, then a small per-pin state machine decides whether the pin is pending. A pin can be level-sensitive, in which case its pending bit simply tracks the selected active level. It can instead be edge-triggered, in which case a rising edge, a falling edge, or either edge sets a pending latch that stays set until software acknowledges it.

Software uses a simple single-cycle register port. Writes take effect at the clock edge and reads are combinational. Through this port it sets the per-pin enable, mask, trigger-mode, polarity and dual-edge bits, reads the raw and masked pending vectors, and writes ones to an acknowledge register to drop edge latches. The combined interrupt output is high whenever any unmasked pin is pending.

Per-pin state machine (`pend_state_e`): state `PEND_IDLE` means no latched edge, and state `PEND_HELD` means an edge has been latched. It has four transitions:
- "arm": `PEND_IDLE` to `PEND_HELD`, taken when the pin is enabled, is in edge mode, and a qualifying edge is seen.
- "acknowledge": `PEND_HELD` to `PEND_IDLE`, taken when the acknowledge bit is written and no qualifying edge arrives in the same cycle.
- "drop": `PEND_HELD` to `PEND_IDLE`, taken when the pin is disabled or switched to level mode.
- "hold": `PEND_HELD` stays in `PEND_HELD` in every other case, including an edge that coincides with an acknowledge.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the enable, trigger-mode, polarity and dual-edge registers read 0, the mask register reads all ones, both status vectors read 0 and `irq_o` is low.
- R2: A pin whose trigger-mode bit is 0 is level-sensitive: its raw pending bit equals the synchronized level when its polarity bit is 1, and the inverted level when it is 0. The pin is never latched, so an acknowledge write leaves the bit unchanged.
- R3: A pin whose trigger-mode bit is 1 and whose dual-edge bit is 0 latches a pending bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. It ignores the opposite edge.
- R4: A pin in edge mode whose dual-edge bit is 1 latches on both rising and falling edges, whatever its polarity bit holds.
- R5: A mask bit of 1 removes the pin from the masked status and from `irq_o`, while its raw status bit still shows the pending condition.
- R6: Writing the acknowledge register clears the edge latch of every pin whose written bit is 1. Pins whose written bit is 0 keep their latch.
- R7: If a qualifying edge and an acknowledge for the same pin fall in the same cycle, the pin stays pending.
- R8: A pin whose enable bit is 0 shows no pending condition. Clearing the enable also discards its edge latch, so re-enabling it does not bring back an old edge.
- R9: `irq_o` is high exactly when the masked status is nonzero.
- R10: A pin change sampled at one rising clock edge becomes visible in a level-mode raw bit after the second rising edge that follows. In an edge-mode raw bit it becomes visible after the third.
- R11: The register word offsets on `reg_addr` are: 0 enable, 1 mask, 2 trigger mode, 3 polarity, 4 dual-edge, 5 masked status, 6 raw status, 7 acknowledge (reads 0), 8 synchronized pin levels. Each bit n of a register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | NPINS | Register write data |
| reg_rdata | output | NPINS | Register read data (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted per-pin state machine shows up in the raw status word at the next read after its wrong transition. A wrong latch appears as a pending bit that survives an acknowledge, or that vanishes while an edge coincides with one, and either is visible one cycle after the acknowledge write. Errors in the configuration registers appear within three cycles of a pin change, because that is the full synchronizer-plus-latch path. Mask and enable errors are exposed immediately on `irq_o` and in the masked status word. The sweep covers every combination of trigger mode, polarity and dual-edge bit against both transition directions, and it checks the result both before and after acknowledging.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RG_ENABLE = 4'd0,
        RG_MASK   = 4'd1,
        RG_TRIG   = 4'd2,
        RG_POL    = 4'd3,
        RG_DUAL   = 4'd4,
        RG_STAT   = 4'd5,
        RG_RAW    = 4'd6,
        RG_ACK    = 4'd7,
        RG_LEVEL  = 4'd8
    } reg_sel_e;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_HELD = 1'b1
    } pend_state_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] lvl_prev_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
            lvl_prev_o <= '0;
        end else begin
            chain_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            lvl_prev_o <= chain_q[STAGES-1];
        end
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      raw_i,
    input  logic [W-1:0]      lvl_i,
    output logic [W-1:0]      en_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      trig_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      dual_o,
    output logic [W-1:0]      ack_o,
    output logic [W-1:0]      masked_o,
    output logic [W-1:0]      rdata_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= '0;
            mask_o <= '1;
            trig_o <= '0;
            pol_o  <= '0;
            dual_o <= '0;
        end else if (we_i) begin
            case (addr_i)
                RG_ENABLE: en_o   <= wdata_i;
                RG_MASK:   mask_o <= wdata_i;
                RG_TRIG:   trig_o <= wdata_i;
                RG_POL:    pol_o  <= wdata_i;
                RG_DUAL:   dual_o <= wdata_i;
                default: ;
            endcase
        end
    end

    // acknowledge is a one-cycle strobe, never stored
    assign ack_o    = (we_i && addr_i == RG_ACK) ? wdata_i : '0;
    assign masked_o = raw_i & ~mask_o;

    always_comb begin
        case (addr_i)
            RG_ENABLE: rdata_o = en_o;
            RG_MASK:   rdata_o = mask_o;
            RG_TRIG:   rdata_o = trig_o;
            RG_POL:    rdata_o = pol_o;
            RG_DUAL:   rdata_o = dual_o;
            RG_STAT:   rdata_o = masked_o;
            RG_RAW:    rdata_o = raw_i;
            RG_LEVEL:  rdata_o = lvl_i;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic edge_i,
    input  logic pol_i,
    input  logic dual_i,
    input  logic lvl_i,
    input  logic prev_i,
    input  logic ack_i,
    output logic hit_o,
    output logic pend_o
);
    pend_state_e state_q, state_d;
    logic rise, fall, act_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rise    = lvl_i & ~prev_i;
        fall    = ~lvl_i & prev_i;
        act_lvl = pol_i ? lvl_i : ~lvl_i;
        hit_o   = dual_i ? (rise | fall) : (pol_i ? rise : fall);
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: begin
                if (en_i && edge_i && hit_o) state_d = PEND_HELD;
            end
            PEND_HELD: begin
                if (!en_i || !edge_i)      state_d = PEND_IDLE;
                else if (ack_i && !hit_o)  state_d = PEND_IDLE;
            end
            default: state_d = PEND_IDLE;
        endcase
    end

    always_comb begin
        if (!en_i)       pend_o = 1'b0;
        else if (edge_i) pend_o = (state_q == PEND_HELD);
        else             pend_o = act_lvl;
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq_o
);
    logic [NPINS-1:0] lvl, lvl_prev;
    logic [NPINS-1:0] en_q, mask_q, trig_q, pol_q, dual_q;
    logic [NPINS-1:0] ack_vec, edge_hit, raw_pend, masked_pend;

    gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .lvl_o(lvl), .lvl_prev_o(lvl_prev)
    );

    gpio_irq_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .raw_i(raw_pend), .lvl_i(lvl),
        .en_o(en_q), .mask_o(mask_q), .trig_o(trig_q), .pol_o(pol_q),
        .dual_o(dual_q), .ack_o(ack_vec), .masked_o(masked_pend),
        .rdata_o(reg_rdata)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .en_i(en_q[n]), .edge_i(trig_q[n]), .pol_i(pol_q[n]),
            .dual_i(dual_q[n]), .lvl_i(lvl[n]), .prev_i(lvl_prev[n]),
            .ack_i(ack_vec[n]), .hit_o(edge_hit[n]), .pend_o(raw_pend[n])
        );
    end

    assign irq_o = |masked_pend;
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] en,
    input logic [W-1:0] mask,
    input logic [W-1:0] trig,
    input logic [W-1:0] raw,
    input logic [W-1:0] masked,
    input logic [W-1:0] ack,
    input logic [W-1:0] hit
);
    a_r1_mask_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '1));

    a_r5_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked & ~raw) == '0) && ((masked & mask) == '0));

    for (genvar n = 0; n < W; n++) begin : g_bit
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && trig[n] && ack[n] && !hit[n]) |=> (!raw[n] || !trig[n]));

        a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (en[n] && trig[n] && hit[n]) |=> (raw[n] || !trig[n] || !en[n]));

        a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !en[n] |-> !raw[n]);
    end
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.W(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .mask(mask_q), .trig(trig_q),
    .raw(raw_pend), .masked(masked_pend), .ack(ack_vec), .hit(edge_hit)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_i = '0;
    logic         reg_we = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gpio_irq_unit #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic run_all();
        logic [N-1:0] v;
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], v);
            check($sformatf("R1 reg %0d", a), v, (a == 1) ? '1 : '0);
        end
        check("R1 irq", {31'd0, irq_o}, '0);

        // R10 latency: pin 0 level active-high, pin 1 rising edge
        wr(4'd0, 32'h3); wr(4'd1, 32'h0); wr(4'd2, 32'h2); wr(4'd3, 32'h3);
        settle(1);
        pin_i[1:0] = 2'b11;
        settle(1); rd(4'd6, v); check("R10 after 1 edge", v, 32'h0);
        settle(1); rd(4'd6, v); check("R10 after 2 edges", v, 32'h1);
        settle(1); rd(4'd6, v); check("R10 after 3 edges", v, 32'h3);
        rd(4'd8, v); check("R11 level word", v, 32'h3);
        rd(4'd7, v); check("R11 ack reads 0", v, 32'h0);
        pin_i = '0; settle(4); wr(4'd7, '1); settle(1);

        // R2 R3 R4 sweep over all trigger/polarity/dual combinations
        for (int c = 0; c < 8; c++) begin
            int p;
            logic ty, po, du;
            logic e_pre, e_rise, e_rack, e_fall, e_fack;
            logic [N-1:0] bit1;
            p  = (c * 4 + 3) % N;
            ty = c[0]; po = c[1]; du = c[2];
            bit1 = 32'h1 << p;
            pin_i = '0; settle(4);
            wr(4'd0, bit1);
            wr(4'd2, ty ? bit1 : '0);
            wr(4'd3, po ? bit1 : '0);
            wr(4'd4, du ? bit1 : '0);
            wr(4'd1, ~bit1);
            wr(4'd7, '1);
            settle(1);
            e_pre  = ty ? 1'b0 : ~po;
            e_rise = ty ? (du | po) : po;
            e_rack = ty ? 1'b0 : po;
            e_fall = ty ? (du | ~po) : ~po;
            e_fack = ty ? 1'b0 : ~po;
            rd(4'd6, v); check($sformatf("R2/R3 cfg%0d idle", c), v, e_pre ? bit1 : '0);
            pin_i[p] = 1'b1; settle(4);
            rd(4'd6, v); check($sformatf("R3/R4 cfg%0d rise raw", c), v, e_rise ? bit1 : '0);
            rd(4'd5, v); check($sformatf("R5 cfg%0d rise stat", c), v, e_rise ? bit1 : '0);
            check($sformatf("R9 cfg%0d rise irq", c), {31'd0, irq_o}, {31'd0, e_rise});
            rd(4'd8, v); check($sformatf("R11 cfg%0d level", c), v, bit1);
            wr(4'd7, bit1); settle(1);
            rd(4'd6, v); check($sformatf("R2/R6 cfg%0d rise ack", c), v, e_rack ? bit1 : '0);
            pin_i[p] = 1'b0; settle(4);
            rd(4'd6, v); check($sformatf("R3/R4 cfg%0d fall raw", c), v, e_fall ? bit1 : '0);
            check($sformatf("R9 cfg%0d fall irq", c), {31'd0, irq_o}, {31'd0, e_fall});
            wr(4'd7, bit1); settle(1);
            rd(4'd6, v); check($sformatf("R2/R6 cfg%0d fall ack", c), v, e_fack ? bit1 : '0);
        end

        // R5 R9 masking: pins 5 and 6 rising edge, all masked
        pin_i = '0; settle(4);
        wr(4'd0, 32'h60); wr(4'd2, 32'h60); wr(4'd3, 32'h60); wr(4'd4, 32'h0);
        wr(4'd1, '1); wr(4'd7, '1);
        pin_i[6:5] = 2'b11; settle(4);
        rd(4'd6, v); check("R5 raw visible when masked", v, 32'h60);
        rd(4'd5, v); check("R5 status hidden when masked", v, 32'h0);
        check("R5 irq low when masked", {31'd0, irq_o}, '0);
        wr(4'd1, ~32'h20);
        rd(4'd5, v); check("R5 status unmasked pin", v, 32'h20);
        check("R9 irq high", {31'd0, irq_o}, 32'h1);

        // R6 only written ones clear
        wr(4'd7, 32'h40); settle(1);
        rd(4'd6, v); check("R6 zero bits keep latch", v, 32'h20);

        // R8 disable discards latch
        wr(4'd0, 32'h40); settle(1);
        rd(4'd6, v); check("R8 disabled not pending", v, 32'h0);
        check("R8 irq low", {31'd0, irq_o}, '0);
        wr(4'd0, 32'h60); settle(1);
        rd(4'd6, v); check("R8 re-enable no old edge", v, 32'h0);

        // R7 edge coincides with acknowledge: pin 9 dual edge
        pin_i = '0; settle(4);
        wr(4'd0, 32'h200); wr(4'd2, 32'h200); wr(4'd4, 32'h200); wr(4'd3, 32'h0);
        wr(4'd7, '1);
        pin_i[9] = 1'b1; settle(4);
        rd(4'd6, v); check("R7 setup pending", v, 32'h200);
        pin_i[9] = 1'b0;
        settle(2);
        wr(4'd7, 32'h200); settle(1);
        rd(4'd6, v); check("R7 edge wins over ack", v, 32'h200);
        wr(4'd7, 32'h200); settle(1);
        rd(4'd6, v); check("R6 later ack clears", v, 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule